// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This controller writes a block of intended data into a byte-wide UV-erasable or one-time-programmable EPROM using the fast pulse-and-verify method. Once started, it walks the address space upward from zero. For each byte it raises the high supply and the programming voltage, drives the address and data, and fires timed chip-enable pulses. After each pulse it removes the programming voltage and reads the byte back. A byte that does not match gets another pulse, up to a fixed cap.

When every byte has verified, both supplies are dropped and the whole array is read once more at normal supply. The controller raises `done` only if every byte matches in that final pass. Any failure, whether from a byte that runs out of pulses or from a mismatch in the final pass, raises `fail`. The failing address and the pulse count are then reported.

The intended data comes from a combinational byte source: the controller presents `src_addr` and takes `src_data` in the same cycle. All timing is given in microseconds and scaled by the parameter `CLK_PER_US`. The supply and voltage enables are logic levels only.

Top module: `eprom_prog_seq`

## Requirements
- R1: After `start`, bytes are programmed in ascending address order from 0 to 2^ADDR_W-1, each receiving at least one pulse before its verify read.
- R2: A programming pulse holds `dev_ce_n` low with `dev_doe`, `dev_vpp_en` and `dev_vhi_en` high for PULSE_US×CLK_PER_US cycles (100 µs by default, inside the 95–105 µs window).
- R3: `dev_addr` and `dev_dout` are driven (`dev_doe`=1) and stable for at least 2 µs before `dev_ce_n` falls for a pulse, and stay unchanged for at least 2 µs after it rises.
- R4: `dev_vhi_en` and `dev_vpp_en` are both high for at least 2 µs before each pulse, and `dev_vhi_en` stays high through each per-byte verify read.
- R5: A verify read has `dev_ce_n`=0, `dev_oe_n`=0, `dev_doe`=0 and `dev_vpp_en`=0. `dev_oe_n` falls no sooner than 2 µs after `dev_vpp_en` falls, and `dev_din` is sampled at least 1 µs after the read begins.
- R6: A byte that reads back wrong gets another pulse followed by another verify, and a byte that reads back right moves the sequence to the next address, so each byte receives exactly as many pulses as it needs to verify.
- R7: When a byte still mismatches after MAX_PULSES (25) pulses, the sequence stops. `fail`=1, `fail_addr` holds that address and `fail_pulses`=25. No further pulse is applied, and every device control returns to idle (`dev_ce_n`=1, `dev_oe_n`=1, `dev_doe`=0, both supply enables 0).
- R8: After the last byte, both supply enables stay low for at least 2 µs. Every address is then read in ascending order at normal supply. A mismatch raises `fail` with `fail_addr` at that address and `fail_pulses`=0.
- R9: `done` rises only after the final pass has read every address without a mismatch. `done` and `fail` are never both high, and both hold until the next `start` clears them.
- R10: During reset and after it, with no `start`, `done`=0, `fail`=0, `dev_ce_n`=1, `dev_oe_n`=1, `dev_doe`=0, `dev_vpp_en`=0 and `dev_vhi_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a programming run when idle |
| done | output | 1 | Whole array programmed and confirmed |
| fail | output | 1 | Run aborted on a byte or compare failure |
| fail_addr | output | ADDR_W | Address at which the failure occurred |
| fail_pulses | output | $clog2(MAX_PULSES+1) | Pulses applied to the failing byte (0 in final pass) |
| src_addr | output | ADDR_W | Address whose intended byte is requested |
| src_data | input | DATA_W | Intended byte for `src_addr` |
| dev_addr | output | ADDR_W | Device address |
| dev_dout | output | DATA_W | Data driven to the device |
| dev_doe | output | 1 | Data drive enable toward the device |
| dev_din | input | DATA_W | Data read back from the device |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_vpp_en | output | 1 | Programming voltage enable |
| dev_vhi_en | output | 1 | Raised supply enable |

## Verification
The device is modelled so that each byte needs a chosen number of in-window pulses before it takes its data, and a read before the sample delay returns the inverted byte. With every byte taking one pulse, the test shows ordering, timing and the final pass. A mix of counts (1, 2, 3 and 25) separates correct retrying from over- or under-pulsing at the cap. A byte that needs 26 pulses isolates the abort path and what it reports. A byte that reads wrong only at normal supply shows that the final pass truly compares and names the right address.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RAMP,
    ST_LOAD,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV,
    ST_VREAD,
    ST_DROP,
    ST_FREAD
  } prog_state_e;

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_prog_track.sv
module eprom_prog_track #(
  parameter int ADDR_W     = 16,
  parameter int MAX_PULSES = 25,
  localparam int PC_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_clr,
  input  logic              addr_inc,
  input  logic              pc_clr,
  input  logic              pc_inc,
  output logic [ADDR_W-1:0] addr,
  output logic [PC_W-1:0]   pulses,
  output logic              addr_last,
  output logic              pc_at_cap
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PC_W-1:0]   pc_q, pc_d;

  always_comb begin
    addr_d = addr_q;
    if (addr_clr)      addr_d = '0;
    else if (addr_inc) addr_d = addr_q + 1'b1;
    pc_d = pc_q;
    if (pc_clr)        pc_d = '0;
    else if (pc_inc)   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pc_q   <= '0;
    end else begin
      addr_q <= addr_d;
      pc_q   <= pc_d;
    end
  end

  assign addr      = addr_q;
  assign pulses    = pc_q;
  assign addr_last = &addr_q;
  assign pc_at_cap = (pc_q == PC_W'(MAX_PULSES));

  // R7
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= PC_W'(MAX_PULSES));

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_PER_US = 125,
  parameter int MAX_PULSES = 25,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int SAMPLE_US  = 1,
  localparam int PC_W      = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [PC_W-1:0]   fail_pulses,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_dout,
  output logic              dev_doe,
  input  logic [DATA_W-1:0] dev_din,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_vpp_en,
  output logic              dev_vhi_en
);

  localparam int CYC_SET   = SETUP_US * CLK_PER_US;
  localparam int CYC_PULSE = PULSE_US * CLK_PER_US;
  localparam int CYC_SAMP  = SAMPLE_US * CLK_PER_US;
  localparam int TMR_W     = $clog2(CYC_PULSE + 1);
  localparam logic [TMR_W-1:0] LD_SET   = TMR_W'(CYC_SET - 1);
  localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(CYC_PULSE - 1);
  localparam logic [TMR_W-1:0] LD_SAMP  = TMR_W'(CYC_SAMP - 1);

  prog_state_e       state_q, state_d;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              addr_clr, addr_inc, pc_clr, pc_inc;
  logic [ADDR_W-1:0] addr;
  logic [PC_W-1:0]   pulses;
  logic              addr_last, pc_at_cap;
  logic              done_q, done_d, fail_q, fail_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [PC_W-1:0]   fpc_q, fpc_d;
  logic              match;

  assign match = (dev_din == src_data);

  eprom_prog_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  eprom_prog_track #(.ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES)) u_track (
    .clk(clk), .rst_n(rst_n), .addr_clr(addr_clr), .addr_inc(addr_inc),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .addr(addr), .pulses(pulses),
    .addr_last(addr_last), .pc_at_cap(pc_at_cap)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    pc_clr   = 1'b0;
    pc_inc   = 1'b0;
    done_d   = done_q;
    fail_d   = fail_q;
    faddr_d  = faddr_q;
    fpc_d    = fpc_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_RAMP;
        addr_clr = 1'b1;
        pc_clr   = 1'b1;
        done_d   = 1'b0;
        fail_d   = 1'b0;
      end
      ST_RAMP:  if (tmr_exp) state_d = ST_LOAD;
      ST_LOAD:  if (tmr_exp) begin state_d = ST_PULSE; pc_inc = 1'b1; end
      ST_PULSE: if (tmr_exp) state_d = ST_HOLD;
      ST_HOLD:  if (tmr_exp) state_d = ST_RECOV;
      ST_RECOV: if (tmr_exp) state_d = ST_VREAD;
      ST_VREAD: if (tmr_exp) begin
        if (match) begin
          pc_clr = 1'b1;
          if (addr_last) begin
            state_d  = ST_DROP;
            addr_clr = 1'b1;
          end else begin
            state_d  = ST_RAMP;
            addr_inc = 1'b1;
          end
        end else if (pc_at_cap) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          faddr_d = addr;
          fpc_d   = pulses;
        end else begin
          state_d = ST_RAMP;
        end
      end
      ST_DROP:  if (tmr_exp) state_d = ST_FREAD;
      ST_FREAD: if (tmr_exp) begin
        if (!match) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
          faddr_d = addr;
          fpc_d   = '0;
        end else if (addr_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          addr_inc = 1'b1;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d != state_q) tmr_load = 1'b1;
  end

  always_comb begin
    unique case (state_d)
      ST_PULSE:          tmr_val = LD_PULSE;
      ST_VREAD, ST_FREAD: tmr_val = LD_SAMP;
      default:           tmr_val = LD_SET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fpc_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
      fpc_q   <= fpc_d;
    end
  end

  assign done        = done_q;
  assign fail        = fail_q;
  assign fail_addr   = faddr_q;
  assign fail_pulses = fpc_q;
  assign src_addr    = addr;
  assign dev_addr    = addr;
  assign dev_dout    = src_data;
  assign dev_doe     = (state_q == ST_LOAD) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign dev_ce_n    = !((state_q == ST_PULSE) || (state_q == ST_VREAD) || (state_q == ST_FREAD));
  assign dev_oe_n    = !((state_q == ST_VREAD) || (state_q == ST_FREAD));
  assign dev_vpp_en  = (state_q == ST_RAMP) || (state_q == ST_LOAD) ||
                       (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign dev_vhi_en  = dev_vpp_en || (state_q == ST_RECOV) || (state_q == ST_VREAD);

  // R3
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_ce_n) |-> $stable(dev_addr));

  // R5
  oe_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_vpp_en) |=> dev_oe_n);

  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R8
  done_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(dev_vhi_en));

endmodule

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;

  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int CPU   = 4;
  localparam int DEPTH = 1 << AW;
  localparam int CAP   = 25;
  localparam int PCW   = $clog2(CAP + 1);

  logic          clk, rst_n, start;
  logic          done, fail;
  logic [AW-1:0] fail_addr, src_addr, dev_addr;
  logic [PCW-1:0] fail_pulses;
  logic [DW-1:0] src_data, dev_dout, dev_din;
  logic          dev_doe, dev_ce_n, dev_oe_n, dev_vpp_en, dev_vhi_en;

  eprom_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_PER_US(CPU), .MAX_PULSES(CAP)) u_eprom_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_pulses(fail_pulses), .src_addr(src_addr),
    .src_data(src_data), .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_doe(dev_doe),
    .dev_din(dev_din), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
    .dev_vpp_en(dev_vpp_en), .dev_vhi_en(dev_vhi_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;

  // device model state
  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] want [DEPTH];
  int need [DEPTH];
  int pcnt [DEPTH];
  int flip_addr;
  int ce_lo, stab, vp_on, vp_off, vh_off, hr, rd_age, last_paddr;
  int fr_next, fr_count, vr_hi, pulses_total;
  int v_r1, v_r2, v_r3, v_r4, v_r5, v_r8, v_r9;
  bit hold_act;
  logic p_ce, p_oe, p_vpp, p_doe;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_dout;

  assign src_data = want[src_addr];
  assign dev_din  = (rd_age >= 1) ?
                    (mem[dev_addr] ^ ((!dev_vhi_en && int'(dev_addr) == flip_addr) ? 8'h01 : 8'h00)) :
                    ~mem[dev_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit chg = (dev_addr != p_addr) || (dev_doe != p_doe) || (dev_dout != p_dout);
      stab   = chg ? 0 : stab + 1;
      vp_on  = (dev_vpp_en && dev_vhi_en) ? vp_on + 1 : 0;
      vp_off = dev_vpp_en ? 0 : vp_off + 1;
      vh_off = dev_vhi_en ? 0 : vh_off + 1;
      rd_age = (!dev_ce_n && !dev_oe_n && dev_addr == p_addr) ? rd_age + 1 :
               ((!dev_ce_n && !dev_oe_n) ? 1 : 0);
      if (hold_act) begin
        hr++;
        if (chg) begin
          if (hr < 2 * CPU) v_r3++;
          hold_act = 1'b0;
        end
      end
      if (p_ce && !dev_ce_n) begin
        if (dev_vpp_en) begin
          if (stab < 2 * CPU || !dev_doe) v_r3++;
          if (vp_on < 2 * CPU) v_r4++;
          if (int'(dev_addr) < last_paddr || fail) v_r1++;
          last_paddr = int'(dev_addr);
        end
        ce_lo = 0;
      end
      if (!dev_ce_n) ce_lo++;
      if (!dev_ce_n && dev_vpp_en && (!dev_vhi_en || !dev_doe)) v_r2++;
      if (!p_ce && dev_ce_n && p_vpp) begin
        if (ce_lo < 95 * CPU || ce_lo > 105 * CPU) v_r2++;
        else begin
          pcnt[p_addr]++;
          pulses_total++;
          if (pcnt[p_addr] >= need[p_addr]) mem[p_addr] = mem[p_addr] & p_dout;
        end
        hold_act = 1'b1;
        hr = 0;
      end
      if (!dev_oe_n && (dev_doe || dev_vpp_en || dev_ce_n)) v_r5++;
      if (p_oe && !dev_oe_n) begin
        if (vp_off < 2 * CPU) v_r5++;
        if (dev_vhi_en) vr_hi++;
      end
      if (!dev_oe_n && !dev_vhi_en && (p_oe || dev_addr != p_addr)) begin
        if (vh_off < 2 * CPU || int'(dev_addr) != fr_next) v_r8++;
        fr_next++;
        fr_count++;
      end
      if (done && fr_count != DEPTH && !hold_act && p_ce && dev_ce_n && $rose(done)) v_r9++;
      p_ce = dev_ce_n; p_oe = dev_oe_n; p_vpp = dev_vpp_en; p_doe = dev_doe;
      p_addr = dev_addr; p_dout = dev_dout;
    end
  end

  // done must never rise before the final pass has covered the array (R9)
  logic done_prev;
  always @(negedge clk) begin
    if (rst_n && done && !done_prev && fr_count != DEPTH) v_r9++;
    done_prev = done;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prep(input int seed, input int flip);
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]  = 8'hFF;
      want[a] = 8'((a * 37 + seed) ^ 8'h5A);
      need[a] = 1;
      pcnt[a] = 0;
    end
    flip_addr = flip;
    ce_lo = 0; stab = 0; vp_on = 0; vp_off = 0; vh_off = 0; hr = 0; rd_age = 0;
    last_paddr = 0; fr_next = 0; fr_count = 0; vr_hi = 0; pulses_total = 0;
    v_r1 = 0; v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r8 = 0; v_r9 = 0;
    hold_act = 1'b0;
  endtask

  task automatic run_seq(output bit timed_out);
    int wd = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 fail cleared by start", int'(fail), 0);
    chk("R9 done cleared by start", int'(done), 0);
    timed_out = 1'b0;
    while (!done && !fail) begin
      @(negedge clk);
      wd++;
      if (wd > 60000) begin timed_out = 1'b1; break; end
    end
    chk("watchdog", int'(timed_out), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic timing_checks();
    chk("R1 order", v_r1, 0);
    chk("R2 pulse shape", v_r2, 0);
    chk("R3 setup/hold", v_r3, 0);
    chk("R4 supply lead", v_r4, 0);
    chk("R5 verify read", v_r5, 0);
    chk("R8 final pass order", v_r8, 0);
    chk("R9 early done", v_r9, 0);
  endtask

  task automatic idle_checks(input string req);
    chk({req, " ce_n idle"}, int'(dev_ce_n), 1);
    chk({req, " oe_n idle"}, int'(dev_oe_n), 1);
    chk({req, " doe idle"}, int'(dev_doe), 0);
    chk({req, " vpp idle"}, int'(dev_vpp_en), 0);
    chk({req, " vhi idle"}, int'(dev_vhi_en), 0);
  endtask

  task automatic t_reset();
    chk("R10 done", int'(done), 0);
    chk("R10 fail", int'(fail), 0);
    idle_checks("R10");
  endtask

  task automatic t_single_pulse();
    bit to;
    int bad = 0;
    prep(3, -1);
    want[6] = 8'hFF;
    run_seq(to);
    chk("R9 done", int'(done), 1);
    for (int a = 0; a < DEPTH; a++) if (mem[a] != want[a] || pcnt[a] != 1) bad++;
    chk("R1 every byte pulsed once and written", bad, 0);
    chk("R4 verify reads at raised supply", vr_hi, DEPTH);
    chk("R8 final reads", fr_count, DEPTH);
    timing_checks();
  endtask

  task automatic t_retry();
    bit to;
    int bad = 0;
    prep(91, -1);
    need[1] = 3; need[4] = CAP; need[6] = 2;
    run_seq(to);
    chk("R6 done after retries", int'(done), 1);
    for (int a = 0; a < DEPTH; a++) if (pcnt[a] != need[a]) bad++;
    chk("R6 pulses equal need", bad, 0);
    chk("R6 total pulses", pulses_total, 5 + 3 + CAP + 2);
    chk("R5 one verify per pulse", vr_hi, pulses_total);
    timing_checks();
  endtask

  task automatic t_cap();
    bit to;
    prep(200, -1);
    need[5] = CAP + 1;
    run_seq(to);
    chk("R7 fail", int'(fail), 1);
    chk("R7 done low", int'(done), 0);
    chk("R7 fail_addr", int'(fail_addr), 5);
    chk("R7 fail_pulses", int'(fail_pulses), CAP);
    chk("R7 pulses at addr5", pcnt[5], CAP);
    chk("R7 no pulse past failing byte", pcnt[6] + pcnt[7], 0);
    chk("R7 no final pass", fr_count, 0);
    idle_checks("R7");
    timing_checks();
  endtask

  task automatic t_final_mismatch();
    bit to;
    prep(17, 2);
    run_seq(to);
    chk("R8 fail", int'(fail), 1);
    chk("R8 done low", int'(done), 0);
    chk("R8 fail_addr", int'(fail_addr), 2);
    chk("R8 fail_pulses", int'(fail_pulses), 0);
    chk("R8 reads before stop", fr_count, 3);
    chk("R8 all bytes pulsed", pulses_total, DEPTH);
    idle_checks("R8");
    timing_checks();
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    p_ce = 1'b1; p_oe = 1'b1; p_vpp = 1'b0; p_doe = 1'b0; p_addr = '0; p_dout = '0;
    done_prev = 1'b0;
    prep(0, -1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_pulse();
    t_retry();
    t_cap();
    t_final_mismatch();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule